// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer, 9 bits wide by default. A write clock and a read clock drive its two sides, and they may be unrelated. Each side has its own active-low boundary flag: `fullN` belongs to the write side and `emptyN` to the read side. Two more active-low flags give early warning. `afN` is the almost-full flag and `aeN` is the almost-empty flag. Each compares the fill level against its own offset register. The pointers cross between the clock domains as Gray codes through two-flop synchronisers. Each flag is computed in the domain that has to act on it.

The write side has a primary enable, `wrEn`, and an auxiliary pin, `wrAux`. The role of `wrAux` is fixed by its level while reset is held.

- **Dual-enable mode** (`wrAux` high during reset): both enables must be high for a FIFO write.
- **Load mode** (`wrAux` low during reset): `wrAux` becomes a strobe for the offset registers. With `wrEn`, each write-clock edge writes the next offset register. With both read enables, each read-clock edge returns the next offset register on `dataOut`.

Offset registers are visited round-robin in the order AE-low, AE-high, AF-low, AF-high. Each offset is `{high, low}`, with the high part occupying the upper DATA_W bits.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high and after its release: `emptyN`=0, `fullN`=1, `aeN`=0, `afN`=1 and `dataOut`=0. Both offsets return to 7 (low part 7, high part 0). Both offset-sequence positions return to AE-low.
- R2: Words leave in the order written. A FIFO read happens only when `rdEnA` and `rdEnB` are both high on a read-clock edge. In dual-enable mode a write needs both `wrEn` and `wrAux` high. In load mode a write needs `wrEn` high and `wrAux` low.
- R3: `fullN` goes low once DEPTH words are unread. While it is low, writes are dropped and stored words are kept.
- R4: `emptyN` is low when no word is unread. While it is low, reads do nothing and `dataOut` holds its value.
- R5: Once both pointers have settled, `aeN` is low exactly when the unread count is at most the almost-empty offset.
- R6: Once both pointers have settled, `afN` is low exactly when the unread count is at least DEPTH minus the almost-full offset.
- R7: If `wrAux` is high during reset, a pulse on `wrEn` with `wrAux` low stores nothing.
- R8: In load mode, each write-clock edge with `wrEn` and `wrAux` high stores `dataIn` into the next offset register in the order AE-low(0), AE-high(1), AF-low(2), AF-high(3), wrapping after 3. The new offsets drive the flags.
- R9: In load mode, each read-clock edge with `wrAux`, `rdEnA` and `rdEnB` high loads the next offset register into `dataOut`, in the same wrapping order. No FIFO word is consumed.
- R10: After the FIFO was empty, with both read enables held high, the first written word appears on `dataOut` one read-clock edge after `emptyN` rises. `emptyN` then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high, held for several edges of both clocks |
| wrEn | input | 1 | Primary write enable |
| wrAux | input | 1 | Second write enable, or offset load strobe (role sampled during reset) |
| dataIn | input | DATA_W | Write data or offset value |
| rdEnA | input | 1 | First read enable |
| rdEnB | input | 1 | Second read enable |
| dataOut | output | DATA_W | Registered read data or offset readback |
| emptyN | output | 1 | Empty flag, active low, read domain |
| fullN | output | 1 | Full flag, active low, write domain |
| aeN | output | 1 | Almost-empty flag, active low, read domain |
| afN | output | 1 | Almost-full flag, active low, write domain |

## Verification
A write on one clock and a read on the other can land in the same time window while the FIFO sits at its full or empty boundary. In that window the flag must block one side while the other side moves the pointer it is waiting on. The bench streams forty words with write enables gated on two of every three cycles and reads gated on alternate cycles at a slower clock. This keeps the buffer bouncing against full. Both sides decide, from the flag sampled before each edge, whether a transfer happens, and every read word is compared with the logged write order.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofsSel_e;

  typedef struct packed {
    logic    memWr;
    logic    ofsWr;
    ofsSel_e ofsSel;
  } wrStrobe_t;

  typedef struct packed {
    logic    memRd;
    logic    ofsRd;
    ofsSel_e ofsSel;
  } rdStrobe_t;

endpackage

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 18
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAux,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic [OFS_W-1:0]  aeOfs,
  input  logic [OFS_W-1:0]  afOfs,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              fullN,
  output logic              aeN,
  output logic              afN
);

  localparam int PW    = ADDR_W + 1;
  localparam int CW    = ((OFS_W > PW) ? OFS_W : PW) + 2;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wrLoadMode;
  logic [PW-1:0] wPtr, wGray, rq1, rq2;
  logic [PW-1:0] wPtrNext, wCount;
  ofsSel_e       wrSel;
  logic          wrWant;

  always_comb begin
    wrWant       = wrLoadMode ? (wrEn & ~wrAux) : (wrEn & wrAux);
    wrStb.memWr  = wrWant & fullN;
    wrStb.ofsWr  = wrLoadMode & wrEn & wrAux;
    wrStb.ofsSel = wrSel;
    wPtrNext     = wPtr + PW'(wrStb.memWr);
    wCount       = wPtrNext - gray2bin(rq2);
  end

  assign wrAddr = wPtr[ADDR_W-1:0];

  always_ff @(posedge wClk) begin
    if (rst) begin
      wrLoadMode <= ~wrAux;
      wPtr       <= '0;
      wGray      <= '0;
      rq1        <= '0;
      rq2        <= '0;
      fullN      <= 1'b1;
      afN        <= 1'b1;
      wrSel      <= OFS_AE_LO;
    end else begin
      wPtr  <= wPtrNext;
      wGray <= bin2gray(wPtrNext);
      rq1   <= rGray;
      rq2   <= rq1;
      fullN <= ~(wCount == PW'(DEPTH));
      afN   <= ~((CW'(wCount) + CW'(afOfs)) >= CW'(DEPTH));
      if (wrStb.ofsWr) wrSel <= ofsSel_e'(wrSel + 2'd1);
    end
  end

  // ---------------- read domain ----------------
  logic          rdLoadMode;
  logic [PW-1:0] rPtr, rGray, wq1, wq2;
  logic [PW-1:0] rPtrNext, rCount;
  ofsSel_e       rdSel;
  logic          rdBoth;

  always_comb begin
    rdBoth       = rdEnA & rdEnB;
    rdStb.ofsRd  = rdLoadMode & wrAux & rdBoth;
    rdStb.memRd  = rdBoth & emptyN & ~rdStb.ofsRd;
    rdStb.ofsSel = rdSel;
    rPtrNext     = rPtr + PW'(rdStb.memRd);
    rCount       = gray2bin(wq2) - rPtrNext;
  end

  assign rdAddr = rPtr[ADDR_W-1:0];

  always_ff @(posedge rClk) begin
    if (rst) begin
      rdLoadMode <= ~wrAux;
      rPtr       <= '0;
      rGray      <= '0;
      wq1        <= '0;
      wq2        <= '0;
      emptyN     <= 1'b0;
      aeN        <= 1'b0;
      rdSel      <= OFS_AE_LO;
    end else begin
      rPtr   <= rPtrNext;
      rGray  <= bin2gray(rPtrNext);
      wq1    <= wGray;
      wq2    <= wq1;
      emptyN <= ~(rCount == '0);
      aeN    <= ~(CW'(rCount) <= CW'(aeOfs));
      if (rdStb.ofsRd) rdSel <= ofsSel_e'(rdSel + 2'd1);
    end
  end

endmodule

// File: rtl/dcfifo_dpath.sv
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 11,
  parameter int DEFAULT_OFS = 7
) (
  input  logic                wClk,
  input  logic                rClk,
  input  logic                rst,
  input  wrStrobe_t           wrStb,
  input  rdStrobe_t           rdStb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [2*DATA_W-1:0] aeOfs,
  output logic [2*DATA_W-1:0] afOfs
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NOFS  = 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ofsReg [NOFS];

  always_ff @(posedge wClk) begin
    if (wrStb.memWr) mem[wrAddr] <= dataIn;
  end

  for (genvar g = 0; g < NOFS; g++) begin : g_ofs
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == OFS_AE_LO || g == OFS_AF_LO) ? DATA_W'(DEFAULT_OFS) : '0;
    always_ff @(posedge wClk) begin
      if (rst)                                   ofsReg[g] <= RST_VAL;
      else if (wrStb.ofsWr && wrStb.ofsSel == g) ofsReg[g] <= dataIn;
    end
  end

  assign aeOfs = {ofsReg[OFS_AE_HI], ofsReg[OFS_AE_LO]};
  assign afOfs = {ofsReg[OFS_AF_HI], ofsReg[OFS_AF_LO]};

  always_ff @(posedge rClk) begin
    if (rst)              dataOut <= '0;
    else if (rdStb.ofsRd) dataOut <= ofsReg[rdStb.ofsSel];
    else if (rdStb.memRd) dataOut <= mem[rdAddr];
  end

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcfifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 2048,
  parameter int DEFAULT_OFS = 7
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAux,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEnA,
  input  logic              rdEnB,
  output logic [DATA_W-1:0] dataOut,
  output logic              emptyN,
  output logic              fullN,
  output logic              aeN,
  output logic              afN
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFS_W  = 2 * DATA_W;

  wrStrobe_t         wrStb;
  rdStrobe_t         rdStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [OFS_W-1:0]  aeOfs, afOfs;

  dcfifo_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
    .wClk(wClk), .rClk(rClk), .rst(rst),
    .wrEn(wrEn), .wrAux(wrAux), .rdEnA(rdEnA), .rdEnB(rdEnB),
    .aeOfs(aeOfs), .afOfs(afOfs),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .aeN(aeN), .afN(afN)
  );

  dcfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEFAULT_OFS(DEFAULT_OFS)) u_dpath (
    .wClk(wClk), .rClk(rClk), .rst(rst),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut), .aeOfs(aeOfs), .afOfs(afOfs)
  );

endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input logic              wClk,
  input logic              rClk,
  input logic              rst,
  input logic              emptyN,
  input logic              fullN,
  input logic              aeN,
  input logic              afN,
  input logic [DATA_W-1:0] dataOut,
  input wrStrobe_t         wrStb,
  input rdStrobe_t         rdStb
);

  // R3: no memory write issued while the full flag is low
  p_no_overflow_r3: assert property (@(posedge wClk) disable iff (rst)
    !fullN |-> !wrStb.memWr);

  // R4: output register holds while empty and no offset readback
  p_hold_when_empty_r4: assert property (@(posedge rClk) disable iff (rst)
    (!emptyN && !rdStb.ofsRd) |=> $stable(dataOut));

  // R5: an empty FIFO is always also almost empty
  p_ae_covers_empty_r5: assert property (@(posedge rClk) disable iff (rst)
    !emptyN |-> !aeN);

  // R6: a full FIFO is always also almost full
  p_af_covers_full_r6: assert property (@(posedge wClk) disable iff (rst)
    !fullN |-> !afN);

  // R9: offset readback and FIFO read never share an edge
  p_rd_exclusive_r9: assert property (@(posedge rClk) disable iff (rst)
    $onehot0({rdStb.memRd, rdStb.ofsRd}));

endmodule

bind dcfifo_pflag dcfifo_chk #(.DATA_W(DATA_W)) u_chk (
  .wClk(wClk), .rClk(rClk), .rst(rst),
  .emptyN(emptyN), .fullN(fullN), .aeN(aeN), .afN(afN),
  .dataOut(dataOut), .wrStb(wrStb), .rdStb(rdStb)
);

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;

  localparam int DW = 9;
  localparam int D  = 16;

  logic          wClk = 1'b0, rClk = 1'b0, rst = 1'b1;
  logic          wrEn = 1'b0, wrAux = 1'b1, rdEnA = 1'b0, rdEnB = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          emptyN, fullN, aeN, afN;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #2.5 wClk = ~wClk;   // 200 MHz write clock
  always #3.5 rClk = ~rClk;   // slower, unrelated read clock

  dcfifo_pflag #(.DATA_W(DW), .DEPTH(D), .DEFAULT_OFS(7)) u0 (
    .wClk(wClk), .rClk(rClk), .rst(rst), .wrEn(wrEn), .wrAux(wrAux),
    .dataIn(dataIn), .rdEnA(rdEnA), .rdEnB(rdEnB), .dataOut(dataOut),
    .emptyN(emptyN), .fullN(fullN), .aeN(aeN), .afN(afN));

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic aux);
    rst = 1'b1; wrAux = aux; wrEn = 0; rdEnA = 0; rdEnB = 0;
    repeat (4) @(posedge wClk);
    repeat (4) @(posedge rClk);
    @(negedge wClk) rst = 1'b0;
    @(negedge rClk);
  endtask

  task automatic settle();
    repeat (6) @(negedge wClk);
    repeat (6) @(negedge rClk);
  endtask

  task automatic wrPulse(input logic [DW-1:0] v);
    @(negedge wClk) begin wrEn = 1; dataIn = v; end
    @(negedge wClk) wrEn = 0;
  endtask

  task automatic rdPulse(input logic a, input logic b);
    @(negedge rClk) begin rdEnA = a; rdEnB = b; end
    @(negedge rClk) begin rdEnA = 0; rdEnB = 0; end
  endtask

  task automatic chkFlags(input string tag, input int cnt, input int ae, input int af);
    check({tag, " R4 emptyN"}, int'(emptyN), (cnt == 0) ? 0 : 1);
    check({tag, " R3 fullN"},  int'(fullN),  (cnt == D) ? 0 : 1);
    check({tag, " R5 aeN"},    int'(aeN),    (cnt <= ae) ? 0 : 1);
    check({tag, " R6 afN"},    int'(afN),    (cnt >= D - af) ? 0 : 1);
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k * 37 + 5);
  endfunction

  initial begin
    logic [DW-1:0] held;
    logic [DW-1:0] wlog [64];
    // ---------- R1 reset, dual-enable mode ----------
    doReset(1'b1);
    check("R1 emptyN", int'(emptyN), 0);
    check("R1 fullN",  int'(fullN),  1);
    check("R1 aeN",    int'(aeN),    0);
    check("R1 afN",    int'(afN),    1);
    check("R1 dataOut", int'(dataOut), 0);

    // ---------- fill sweep with default offsets 7/7 ----------
    for (int k = 1; k <= D; k++) begin
      wrPulse(pat(k));
      settle();
      chkFlags($sformatf("fill%0d", k), k, 7, 7);
    end
    wrPulse(9'h1FF);              // dropped: FIFO full (R3)
    settle();
    check("R3 full after extra write", int'(fullN), 0);
    for (int k = 1; k <= D; k++) begin
      rdPulse(1, 1);
      check("R2 R3 order after overflow attempt", int'(dataOut), int'(pat(k)));
      settle();
      chkFlags($sformatf("drain%0d", k), D - k, 7, 7);
    end

    // ---------- R4 read while empty ----------
    held = dataOut;
    rdPulse(1, 1);
    settle();
    check("R4 dataOut held when empty", int'(dataOut), int'(held));
    check("R4 emptyN stays low", int'(emptyN), 0);

    // ---------- R7 second enable required ----------
    wrAux = 0;
    wrPulse(9'h0AA);
    settle();
    check("R7 no write without second enable", int'(emptyN), 0);
    wrAux = 1;
    wrPulse(9'h055);
    settle();
    rdPulse(1, 0);
    rdPulse(0, 1);
    settle();
    check("R2 single read enable ignored (emptyN)", int'(emptyN), 1);
    check("R2 single read enable ignored (dataOut)", int'(dataOut), int'(held));
    rdPulse(1, 1);
    check("R2 R7 only second word stored", int'(dataOut), 9'h055);

    // ---------- R10 first-word latency ----------
    doReset(1'b1);
    @(negedge rClk) begin rdEnA = 1; rdEnB = 1; end
    wrPulse(9'h1A5);
    begin
      int guard = 0;
      while (emptyN == 1'b0 && guard < 30) begin
        check("R10 dataOut before emptyN rises", int'(dataOut), 0);
        @(negedge rClk);
        guard++;
      end
      check("R10 emptyN rose", int'(emptyN), 1);
      check("R10 dataOut not yet updated", int'(dataOut), 0);
      @(negedge rClk);
      check("R10 first word one edge later", int'(dataOut), 9'h1A5);
      check("R10 emptyN falls again", int'(emptyN), 0);
    end
    rdEnA = 0; rdEnB = 0;

    // ---------- R2 concurrent streaming at full boundary ----------
    doReset(1'b1);
    fork
      begin
        int n = 0, cyc = 0;
        while (n < 40) begin
          @(negedge wClk);
          wrEn = (cyc % 3 != 2);
          dataIn = pat(n + 100);
          if (wrEn && fullN) begin wlog[n] = dataIn; n++; end
          cyc++;
        end
        @(negedge wClk) wrEn = 0;
      end
      begin
        int m = 0, cyc = 0;
        bit pend = 0;
        while (m < 40) begin
          @(negedge rClk);
          if (pend) begin
            check($sformatf("R2 stream word %0d", m), int'(dataOut), int'(wlog[m]));
            m++;
            pend = 0;
          end
          rdEnA = (cyc % 2 == 0); rdEnB = 1;
          if (m < 40 && rdEnA && emptyN) pend = 1;
          else if (m >= 40) rdEnA = 0;
          cyc++;
        end
        rdEnA = 0; rdEnB = 0;
      end
    join
    settle();
    check("R2 stream drained", int'(emptyN), 0);

    // ---------- R8/R9 load mode ----------
    doReset(1'b0);
    wrAux = 1;
    rdPulse(1, 1); check("R9 R1 readback AE lo default", int'(dataOut), 7);
    rdPulse(1, 1); check("R9 R1 readback AE hi default", int'(dataOut), 0);
    rdPulse(1, 1); check("R9 R1 readback AF lo default", int'(dataOut), 7);
    rdPulse(1, 1); check("R9 R1 readback AF hi default", int'(dataOut), 0);
    wrPulse(9'd3); wrPulse(9'h101); wrPulse(9'd5); wrPulse(9'h0C2);
    settle();
    rdPulse(1, 1); check("R8 R9 AE lo", int'(dataOut), 3);
    rdPulse(1, 1); check("R8 R9 AE hi", int'(dataOut), 9'h101);
    rdPulse(1, 1); check("R8 R9 AF lo", int'(dataOut), 5);
    rdPulse(1, 1); check("R8 R9 AF hi", int'(dataOut), 9'h0C2);
    rdPulse(1, 1); check("R9 sequence wraps", int'(dataOut), 3);
    check("R9 no FIFO word consumed or stored", int'(emptyN), 0);
    // rewrite high parts to zero (writes wrap: AE lo, AE hi, AF lo, AF hi)
    wrPulse(9'd3); wrPulse(9'd0); wrPulse(9'd5); wrPulse(9'd0);
    wrAux = 0;
    settle();
    for (int k = 1; k <= D; k++) begin
      wrPulse(pat(k));
      settle();
      chkFlags($sformatf("R8 load fill%0d", k), k, 3, 5);
    end
    rdPulse(1, 1);
    check("R2 load-mode FIFO read", int'(dataOut), int'(pat(1)));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule